// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This block watches every processor access and compares it against four programmable breakpoint slots. Each slot holds an address, a kind filter (instruction fetch, data write, or data read-or-write) and a byte range of one, two or four aligned bytes. When an access overlaps an armed slot, the block sends out a one-cycle debug exception pulse. The cause is logged in a sticky status register. A single-step request also raises the exception, and so does any register access attempted while the access guard is set.

Software reaches the address slots, the control word and the status word through a simple register port. The port reads back combinationally, and a write takes effect on the next clock edge. A task-switch input clears the per-task enables and can mark that the incoming task wants to trap. That mark is reported in the status word when the next exception is taken.

Top module: `brk_match_unit`

## Requirements
- R1: After reset the four addresses, the control word, the status word and the exception output are all zero.
- R2: A slot's 2-bit kind field matches as follows: 00 matches fetches only, 01 matches data writes only, and 11 matches data reads and data writes. The access kind input is 0 for a fetch, 1 for a read and 2 for a write.
- R3: A slot's length field 00/01/11 covers the aligned 1/2/4-byte range that contains its address. An access of size code 0/1/2 (1/2/4 bytes starting at the access address) matches when any of its bytes falls inside that range.
- R4: A kind field of 10 or a length field of 10 never matches.
- R5: When an exception is taken, every slot whose match condition holds in that cycle sets its hit bit (status bits 3:0), even if neither of its enables is set.
- R6: The exception is taken only for a match on a slot with its local or global enable set, for a single-step request, or for a guarded register access. A match on a slot with no enable set raises nothing and logs nothing.
- R7: A task switch clears all local enables (control bits 19:16) and leaves the global enables (bits 23:20) unchanged. It also overrides a control write made in the same cycle.
- R8: An exception that includes a single-step request sets status bit 4. A task switch with the trap flag set makes the next exception set status bit 5.
- R9: Hardware never clears status bits. Only a software write to the status word (select 5) changes them to the written value.
- R10: While the guard bit (control bit 24) is set, any register-port access is blocked: writes are dropped, reads return zero, and an exception is raised. Every exception clears the guard bit.
- R11: `dbg_exc` is high for exactly the one cycle that follows the cycle in which the cause was present.
- R12: Register writes land on the next edge and read back unchanged: selects 0 to 3 are the slot addresses, 4 is control and 5 is status. In the control word, slot n's kind field sits at bits 2n+1:2n and its length field at bits 2n+9:2n+8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | An access is present this cycle |
| acc_kind | input | 2 | 0 fetch, 1 data read, 2 data write |
| acc_addr | input | ADDR_W | First byte address of the access |
| acc_size | input | 2 | 0 one byte, 1 two bytes, 2 four bytes |
| reg_en | input | 1 | Register port access strobe |
| reg_we | input | 1 | 1 write, 0 read |
| reg_sel | input | 3 | Register select (0-3 address, 4 control, 5 status) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| task_sw | input | 1 | Task switch event |
| task_trap | input | 1 | Incoming task requests a trap |
| step_evt | input | 1 | Single-step exception request |
| dbg_exc | output | 1 | Debug exception pulse |

## Verification
The hardest case to reach from the ports is a logged hit on a slot that has no enable set. Such a slot can only leave a mark when some other cause takes the exception in the same cycle. The stimulus therefore drives a write to an unarmed slot's address together with a single-step request, and then reads the status word. A second case is the pending trap mark, which has to survive idle cycles before the next exception reports it. Related orderings are also covered: a task switch in the same cycle as a control write, and a guard trip that is itself an exception clearing the guard.

// File: rtl/brk_pkg.sv
package brk_pkg;
    localparam int NSLOT  = 4;
    localparam int DATA_W = 32;
    localparam int SEL_W  = 3;

    localparam logic [SEL_W-1:0] SEL_CTRL = 3'd4;
    localparam logic [SEL_W-1:0] SEL_STAT = 3'd5;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_READ  = 2'd1,
        KIND_WRITE = 2'd2,
        KIND_NONE  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic [6:0]             rsvd;
        logic                   guard;
        logic [NSLOT-1:0]       glb;
        logic [NSLOT-1:0]       loc;
        logic [NSLOT-1:0][1:0]  lens;
        logic [NSLOT-1:0][1:0]  kinds;
    } ctrl_t;

    typedef struct packed {
        logic [25:0]            rsvd;
        logic                   trap_seen;
        logic                   step_seen;
        logic [NSLOT-1:0]       hit;
    } stat_t;
endpackage

// File: rtl/brk_slot_cmp.sv
module brk_slot_cmp
    import brk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] bp_addr,
    input  logic [1:0]        kind_code,
    input  logic [1:0]        len_code,
    input  logic              acc_valid,
    input  logic [1:0]        acc_kind,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    output logic              hit
);
    localparam int EW = ADDR_W + 1;

    logic          kind_ok, len_ok, size_ok;
    logic [EW-1:0] mask, span, lo, hi, alo, ahi;

    always_comb begin
        unique case (kind_code)
            2'b00:   kind_ok = (acc_kind == KIND_FETCH);
            2'b01:   kind_ok = (acc_kind == KIND_WRITE);
            2'b11:   kind_ok = (acc_kind == KIND_READ) || (acc_kind == KIND_WRITE);
            default: kind_ok = 1'b0;
        endcase

        len_ok = 1'b1;
        unique case (len_code)
            2'b00:   mask = EW'(0);
            2'b01:   mask = EW'(1);
            2'b11:   mask = EW'(3);
            default: begin mask = EW'(0); len_ok = 1'b0; end
        endcase

        size_ok = 1'b1;
        unique case (acc_size)
            2'd0:    span = EW'(0);
            2'd1:    span = EW'(1);
            2'd2:    span = EW'(3);
            default: begin span = EW'(0); size_ok = 1'b0; end
        endcase

        lo  = {1'b0, bp_addr} & ~mask;
        hi  = lo | mask;
        alo = {1'b0, acc_addr};
        ahi = alo + span;

        hit = acc_valid && kind_ok && len_ok && size_ok && (alo <= hi) && (ahi >= lo);
    end
endmodule

// File: rtl/brk_reg_rd.sv
module brk_reg_rd
    import brk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [SEL_W-1:0]             sel,
    input  logic                         blocked,
    input  logic [NSLOT-1:0][ADDR_W-1:0] addr,
    input  ctrl_t                        ctrl,
    input  stat_t                        stat,
    output logic [DATA_W-1:0]            rdata
);
    always_comb begin
        rdata = '0;
        if (!blocked) begin
            if (sel < SEL_W'(NSLOT))
                rdata = DATA_W'(addr[sel[1:0]]);
            else if (sel == SEL_CTRL)
                rdata = ctrl;
            else if (sel == SEL_STAT)
                rdata = stat;
        end
    end
endmodule

// File: rtl/brk_match_unit.sv
module brk_match_unit
    import brk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [1:0]        acc_kind,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              task_sw,
    input  logic              task_trap,
    input  logic              step_evt,
    output logic              dbg_exc
);
    typedef struct packed {
        logic [NSLOT-1:0][ADDR_W-1:0] addr;
        ctrl_t                        ctrl;
        stat_t                        stat;
        logic                         trap_pend;
        logic                         exc;
    } st_t;

    st_t              st_d, st_q;
    logic [NSLOT-1:0] raw_hit;
    logic             blocked, sw_wr, armed_hit, take;

    for (genvar n = 0; n < NSLOT; n++) begin : g_slot
        brk_slot_cmp #(.ADDR_W(ADDR_W)) u_cmp (
            .bp_addr   (st_q.addr[n]),
            .kind_code (st_q.ctrl.kinds[n]),
            .len_code  (st_q.ctrl.lens[n]),
            .acc_valid (acc_valid),
            .acc_kind  (acc_kind),
            .acc_addr  (acc_addr),
            .acc_size  (acc_size),
            .hit       (raw_hit[n])
        );
    end

    brk_reg_rd #(.ADDR_W(ADDR_W)) u_rd (
        .sel     (reg_sel),
        .blocked (blocked),
        .addr    (st_q.addr),
        .ctrl    (st_q.ctrl),
        .stat    (st_q.stat),
        .rdata   (reg_rdata)
    );

    always_comb begin
        st_d      = st_q;
        blocked   = reg_en && st_q.ctrl.guard;
        sw_wr     = reg_en && reg_we && !st_q.ctrl.guard;
        armed_hit = |(raw_hit & (st_q.ctrl.loc | st_q.ctrl.glb));
        take      = armed_hit || step_evt || blocked;

        // software write first; hardware effects below take priority
        if (sw_wr) begin
            if (reg_sel < 3'(NSLOT)) begin
                st_d.addr[reg_sel[1:0]] = reg_wdata[ADDR_W-1:0];
            end else if (reg_sel == SEL_CTRL) begin
                st_d.ctrl      = ctrl_t'(reg_wdata);
                st_d.ctrl.rsvd = '0;
            end else if (reg_sel == SEL_STAT) begin
                st_d.stat      = stat_t'(reg_wdata);
                st_d.stat.rsvd = '0;
            end
        end

        if (task_sw) begin
            st_d.ctrl.loc = '0;
            if (task_trap)
                st_d.trap_pend = 1'b1;
        end

        if (take) begin
            st_d.stat.hit       = st_d.stat.hit | raw_hit;
            st_d.stat.step_seen = st_d.stat.step_seen | step_evt;
            st_d.stat.trap_seen = st_d.stat.trap_seen | st_q.trap_pend;
            st_d.trap_pend      = task_sw && task_trap;
            st_d.ctrl.guard     = 1'b0;
        end

        st_d.exc = take;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign dbg_exc = st_q.exc;
endmodule

// File: rtl/brk_match_chk.sv
module brk_match_chk #(
    parameter int ADDR_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                acc_valid,
    input logic                reg_en,
    input logic                reg_we,
    input logic [2:0]          reg_sel,
    input logic                task_sw,
    input logic                step_evt,
    input logic                dbg_exc,
    input logic                guard,
    input logic [3:0]          loc,
    input logic [3:0]          glb,
    input logic [5:0]          stat,
    input logic [4*ADDR_W-1:0] addr_flat
);
    logic stat_wr, ctrl_wr;
    assign stat_wr = reg_en && reg_we && !guard && (reg_sel == 3'd5);
    assign ctrl_wr = reg_en && reg_we && !guard && (reg_sel == 3'd4);

    assert_step_raises_R8: assert property (@(posedge clk) disable iff (!rst_n)
        step_evt |=> dbg_exc);

    assert_guard_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_exc |-> !guard);

    assert_guard_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && guard) |=> (dbg_exc && $stable(addr_flat)));

    assert_local_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        task_sw |=> (loc == 4'b0));

    assert_global_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (task_sw && !ctrl_wr) |=> $stable(glb));

    assert_status_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> ((stat & $past(stat)) == $past(stat)));

    assert_no_cause_no_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid && !step_evt && !reg_en) |=> !dbg_exc);
endmodule

bind brk_match_unit brk_match_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .reg_en    (reg_en),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .task_sw   (task_sw),
    .step_evt  (step_evt),
    .dbg_exc   (dbg_exc),
    .guard     (st_q.ctrl.guard),
    .loc       (st_q.ctrl.loc),
    .glb       (st_q.ctrl.glb),
    .stat      (st_q.stat[5:0]),
    .addr_flat (st_q.addr)
);

// File: tb/brk_match_unit_bench.sv
module brk_match_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid, reg_en, reg_we, task_sw, task_trap, step_evt;
    logic [1:0]  acc_kind, acc_size;
    logic [31:0] acc_addr, reg_wdata, reg_rdata;
    logic [2:0]  reg_sel;
    logic        dbg_exc;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic  exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    brk_match_unit u_brk_match_unit (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_addr(acc_addr), .acc_size(acc_size),
        .reg_en(reg_en), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .task_sw(task_sw), .task_trap(task_trap),
        .step_evt(step_evt), .dbg_exc(dbg_exc)
    );

    function automatic logic [31:0] ctl(input logic [7:0] kinds, input logic [7:0] lens,
                                        input logic [3:0] loc, input logic [3:0] glb,
                                        input logic guard);
        return {7'b0, guard, glb, loc, lens, kinds};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic quiet();
        acc_valid = 0; acc_kind = 2'd3; acc_addr = '0; acc_size = 2'd0;
        reg_en = 0; reg_we = 0; reg_sel = '0; reg_wdata = '0;
        task_sw = 0; task_trap = 0; step_evt = 0;
    endtask

    // scoreboard driver side: drive one cycle, queue the expected pulse
    task automatic push(input logic e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic acc(input logic [1:0] k, input logic [1:0] sz, input logic [31:0] a,
                       input logic stp, input logic e, input string tag);
        quiet();
        acc_valid = 1; acc_kind = k; acc_size = sz; acc_addr = a; step_evt = stp;
        push(e, tag);
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] v, input logic ts,
                      input logic e, input string tag);
        quiet();
        reg_en = 1; reg_we = 1; reg_sel = s; reg_wdata = v; task_sw = ts;
        push(e, tag);
    endtask

    task automatic rd(input logic [2:0] s, input logic [31:0] v, input logic e, input string tag);
        quiet();
        reg_en = 1; reg_sel = s;
        #2 chk(tag, reg_rdata, v);
        push(e, tag);
    endtask

    task automatic evt(input logic ts, input logic tr, input logic stp, input logic e,
                       input string tag);
        quiet();
        task_sw = ts; task_trap = tr; step_evt = stp;
        push(e, tag);
    endtask

    // scoreboard monitor side
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk({t, " exc"}, {31'b0, dbg_exc}, {31'b0, e});
        end
    end

    initial begin
        #(20ns * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    localparam logic [7:0] KINDS = 8'b01_10_11_00;
    localparam logic [7:0] LENS1 = 8'b10_00_11_00;
    localparam logic [7:0] LENS2 = 8'b00_00_11_00;

    initial begin
        quiet();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset exc", {31'b0, dbg_exc}, 32'd0);
        rd(3'd0, 32'h0, 0, "R1 addr0");
        rd(3'd4, 32'h0, 0, "R1 ctrl");
        rd(3'd5, 32'h0, 0, "R1 status");

        // R12 configuration and readback
        wr(3'd0, 32'h1000, 0, 0, "R12 wr a0");
        wr(3'd1, 32'h2002, 0, 0, "R12 wr a1");
        wr(3'd2, 32'h3000, 0, 0, "R12 wr a2");
        wr(3'd3, 32'h4000, 0, 0, "R12 wr a3");
        wr(3'd4, ctl(KINDS, LENS1, 4'b0010, 4'b0101, 0), 0, 0, "R12 wr ctrl");
        rd(3'd1, 32'h2002, 0, "R12 rd a1");
        rd(3'd4, ctl(KINDS, LENS1, 4'b0010, 4'b0101, 0), 0, "R12 rd ctrl");

        // R2 kind matching, R11 pulse timing
        acc(2'd0, 2'd0, 32'h1000, 0, 1, "R2 fetch hit slot0");
        evt(0, 0, 0, 0, "R11 pulse ends");
        acc(2'd0, 2'd0, 32'h1001, 0, 0, "R2 fetch miss");
        acc(2'd1, 2'd0, 32'h1000, 0, 0, "R2 read vs fetch-only");
        // R3 ranges on slot1 (0x2000..0x2003, reads and writes)
        acc(2'd1, 2'd0, 32'h2003, 0, 1, "R3 read top byte");
        acc(2'd2, 2'd1, 32'h1fff, 0, 1, "R3 straddling half write");
        acc(2'd1, 2'd0, 32'h2004, 0, 0, "R3 past range");
        acc(2'd0, 2'd2, 32'h2000, 0, 0, "R2 fetch vs data slot");
        rd(3'd5, 32'h03, 0, "R5 status slots0,1");

        // R4 reserved encodings
        acc(2'd2, 2'd0, 32'h3000, 0, 0, "R4 reserved kind write");
        acc(2'd1, 2'd0, 32'h3000, 0, 0, "R4 reserved kind read");
        acc(2'd2, 2'd0, 32'h4000, 1, 1, "R8 step with reserved len");
        rd(3'd5, 32'h13, 0, "R4 no slot3 hit, R8 step bit");

        // R9 software clear
        wr(3'd5, 32'h0, 0, 0, "R9 clear status");
        rd(3'd5, 32'h0, 0, "R9 cleared");

        // R5 / R6 unarmed slot3
        wr(3'd4, ctl(KINDS, LENS2, 4'b0010, 4'b0101, 0), 0, 0, "R12 ctrl len3");
        acc(2'd2, 2'd0, 32'h4000, 0, 0, "R6 unarmed match silent");
        rd(3'd5, 32'h0, 0, "R6 nothing logged");
        acc(2'd2, 2'd0, 32'h4000, 1, 1, "R5 step + unarmed match");
        evt(0, 0, 0, 0, "R9 idle");
        rd(3'd5, 32'h18, 0, "R5 R9 sticky hit3+step");

        // R7 task switch
        evt(1, 0, 0, 0, "R7 task switch");
        rd(3'd4, ctl(KINDS, LENS2, 4'b0000, 4'b0101, 0), 0, "R7 loc cleared glb kept");
        acc(2'd1, 2'd0, 32'h2000, 0, 0, "R7 local slot disarmed");
        acc(2'd0, 2'd0, 32'h1000, 0, 1, "R7 global slot armed");
        wr(3'd4, ctl(KINDS, LENS2, 4'b1111, 4'b0101, 0), 1, 0, "R7 write with switch");
        rd(3'd4, ctl(KINDS, LENS2, 4'b0000, 4'b0101, 0), 0, "R7 switch wins");

        // R8 trap mark
        evt(1, 1, 0, 0, "R8 trapping switch");
        evt(0, 0, 0, 0, "R8 idle");
        evt(0, 0, 1, 1, "R8 step");
        rd(3'd5, 32'h39, 0, "R8 trap+step bits");
        wr(3'd5, 32'h0, 0, 0, "R9 clear again");

        // R10 guard
        wr(3'd4, ctl(KINDS, LENS2, 4'b0000, 4'b0101, 1), 0, 0, "R10 set guard");
        wr(3'd0, 32'hdead, 0, 1, "R10 blocked write");
        rd(3'd4, ctl(KINDS, LENS2, 4'b0000, 4'b0101, 0), 0, "R10 guard cleared");
        rd(3'd0, 32'h1000, 0, "R10 addr kept");
        rd(3'd5, 32'h0, 0, "R10 no hit bits");
        wr(3'd4, ctl(KINDS, LENS2, 4'b0000, 4'b0101, 1), 0, 0, "R10 set guard again");
        rd(3'd4, 32'h0, 1, "R10 blocked read");
        rd(3'd4, ctl(KINDS, LENS2, 4'b0000, 4'b0101, 0), 0, "R10 guard off again");

        evt(0, 0, 0, 0, "R11 drain");
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule